// File: doc/BRIEF.md
# PHY Test-Port Register Write Sequencer

This block drives the four-signal test port that a PHY uses to load its internal configuration registers: a test clock, a test enable, an active-high test clear and an 8-bit test data bus. A host hands it one request at a time over a valid/ready interface. The opcode picks a clear sequence, which resets the PHY's internal test state, or a register write that carries a register code byte and a data byte. The block plays the request out as a fixed series of pin steps. Each step lasts a programmable number of system clocks, so that the port runs slowly enough for the PHY.

A write uses two edges of the test clock. The falling edge, with enable high, latches the register code. The rising edge that follows, with enable low, commits the data byte. The clear sequence pulses test clear high between two low steps and keeps the clock high throughout. Back-pressure follows the usual stream rule. A request transfers on the rising clock edge where `req_valid` and `req_ready` are both high. While a sequence runs, `req_ready` stays low. A request that is already presented must be held stable until it is accepted, and it is never lost.

Top module: `phy_tport_seq`

## Requirements
- R1: After reset, `tst_clk` is 1, `tst_en` is 0, `tst_clr` is 0, `tst_din` is 0 and `req_ready` is 1.
- R2: With `req_valid` low and the block idle, `req_ready` stays 1 and the pins keep the rest state of R1.
- R3: A request with `req_op`=1 (clear) plays three steps with the pins {clk,en,clr,din}: {1,0,0,0}, then {1,0,1,0}, then {1,0,0,0}.
- R4: A request with `req_op`=0 (write) plays five steps: {1,0,0,0}, {1,1,0,code}, {0,1,0,code}, {0,0,0,data}, {1,0,0,data}.
- R5: `tst_clk` falls only while `tst_en` is 1, and it rises only while `tst_en` is 0. `tst_en` falls only while `tst_clk` is 0. `tst_din` never changes in the cycle in which `tst_clk` changes. `tst_clr` is high only while the clock is high, enable is low and the bus is zero.
- R6: Each step lasts N = max(`step_div`, 2) system clocks. N is sampled on the acceptance edge, so a later change of `step_div` has no effect on a sequence that is already running.
- R7: `req_ready` falls on the acceptance edge. It returns to 1, with the pins back in the R1 rest state, exactly S*N cycles after that edge, where S is 3 for a clear and 5 for a write.
- R8: A request that is held valid while the block is busy is accepted on the first edge at which `req_ready` is high again, and it then plays its full sequence with its own bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_div | input | DIV_W | Clocks per step; values below 2 are treated as 2 |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request may transfer |
| req_op | input | 1 | 0 = register write, 1 = clear sequence |
| req_code | input | 8 | Register code for a write |
| req_data | input | 8 | Data byte for a write |
| tst_clk | output | 1 | Test clock to the PHY |
| tst_en | output | 1 | Test enable to the PHY |
| tst_clr | output | 1 | Test clear to the PHY, active high |
| tst_din | output | 8 | Test data bus to the PHY |

## Verification
Every pin is registered from the next step. Step k of a sequence is therefore visible in the N cycles that start at edge e0+k*N, where e0 is the acceptance edge, and `req_ready` is high again after edge e0+S*N. Inputs change only on falling edges, and the bench compares the pins and `req_ready` at every falling edge of every step against a step table that it computes itself. The idle cycle after each sequence is checked too. Chained requests change `step_div` in the middle of a sequence and present the next request while the block is busy. This shows that N is latched at acceptance and that the stalled request arrives intact.

// File: rtl/tport_pkg.sv
package tport_pkg;
  localparam int BYTE_W = 8;

  localparam logic OP_WRITE = 1'b0;
  localparam logic OP_CLEAR = 1'b1;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_C_LO0,
    ST_C_HI,
    ST_C_LO1,
    ST_W_SETUP,
    ST_W_CODE,
    ST_W_LATCH,
    ST_W_DATA,
    ST_W_COMMIT
  } tport_step_e;

  typedef struct packed {
    logic              clk;
    logic              en;
    logic              clr;
    logic [BYTE_W-1:0] din;
  } tport_pins_t;

  localparam tport_pins_t PINS_REST = '{clk: 1'b1, en: 1'b0, clr: 1'b0, din: '0};
endpackage

// File: rtl/tport_pacer.sv
module tport_pacer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] div_in,
  input  logic             run,
  output logic             step_end
);
  localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(2);

  logic [DIV_W-1:0] lim_q;
  logic [DIV_W-1:0] cnt_q;

  assign step_end = run && (cnt_q == lim_q - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lim_q <= MIN_DIV;
      cnt_q <= '0;
    end else if (load) begin
      lim_q <= (div_in < MIN_DIV) ? MIN_DIV : div_in;
      cnt_q <= '0;
    end else if (run) begin
      cnt_q <= step_end ? '0 : cnt_q + DIV_W'(1);
    end
  end

  // R6: the step counter never runs past the latched step length
  a_r6_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < lim_q));
  // R6: the latched length is never below two clocks
  a_r6_min_len: assert property (@(posedge clk) disable iff (!rst_n)
    lim_q >= MIN_DIV);
endmodule

// File: rtl/tport_stepper.sv
module tport_stepper
  import tport_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        accept,
  input  logic        op,
  input  logic        step_end,
  output tport_step_e state_d,
  output logic        busy
);
  tport_step_e state_q;

  always_comb begin
    state_d = state_q;
    if (accept) begin
      state_d = (op == OP_CLEAR) ? ST_C_LO0 : ST_W_SETUP;
    end else if (step_end) begin
      case (state_q)
        ST_C_LO0:    state_d = ST_C_HI;
        ST_C_HI:     state_d = ST_C_LO1;
        ST_C_LO1:    state_d = ST_IDLE;
        ST_W_SETUP:  state_d = ST_W_CODE;
        ST_W_CODE:   state_d = ST_W_LATCH;
        ST_W_LATCH:  state_d = ST_W_DATA;
        ST_W_DATA:   state_d = ST_W_COMMIT;
        ST_W_COMMIT: state_d = ST_IDLE;
        default:     state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign busy = (state_q != ST_IDLE);

  // R6: a step entered while busy is held for at least one more cycle
  a_r6_step_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(state_q) && busy) |=> $stable(state_q));
  // R7: a sequence ends only through its final step
  a_r7_exit_path: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy)) |-> ($past(state_q) == ST_C_LO1 || $past(state_q) == ST_W_COMMIT));
endmodule

// File: rtl/tport_drive.sv
module tport_drive
  import tport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  tport_step_e       state_d,
  input  logic [BYTE_W-1:0] code,
  input  logic [BYTE_W-1:0] data,
  output tport_pins_t       pins
);
  tport_pins_t pins_d;

  always_comb begin
    pins_d = PINS_REST;
    case (state_d)
      ST_C_HI:     pins_d.clr = 1'b1;
      ST_W_CODE:   begin pins_d.en = 1'b1; pins_d.din = code; end
      ST_W_LATCH:  begin pins_d.clk = 1'b0; pins_d.en = 1'b1; pins_d.din = code; end
      ST_W_DATA:   begin pins_d.clk = 1'b0; pins_d.din = data; end
      ST_W_COMMIT: pins_d.din = data;
      default:     pins_d = PINS_REST;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pins <= PINS_REST;
    else        pins <= pins_d;
  end

  // R5: the code is latched on a falling clock only with enable high
  a_r5_fall_with_en: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pins.clk) |-> pins.en);
  // R5: the data is committed on a rising clock only with enable low
  a_r5_rise_without_en: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pins.clk) |-> !pins.en);
  // R5: enable drops only while the clock is low
  a_r5_en_drop_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pins.en) |-> !pins.clk);
  // R5: the bus is steady across every test clock edge
  a_r5_din_steady: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pins.clk) || $rose(pins.clk)) |-> $stable(pins.din));
  // R5: clear only with clock high, enable low and a quiet bus
  a_r5_clr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    pins.clr |-> (pins.clk && !pins.en && pins.din == '0));
endmodule

// File: rtl/phy_tport_seq.sv
module phy_tport_seq
  import tport_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  step_div,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_op,
  input  logic [BYTE_W-1:0] req_code,
  input  logic [BYTE_W-1:0] req_data,
  output logic              tst_clk,
  output logic              tst_en,
  output logic              tst_clr,
  output logic [BYTE_W-1:0] tst_din
);
  logic              busy;
  logic              accept;
  logic              step_end;
  tport_step_e       state_d;
  tport_pins_t       pins;
  logic [BYTE_W-1:0] code_q;
  logic [BYTE_W-1:0] data_q;

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q <= '0;
      data_q <= '0;
    end else if (accept) begin
      code_q <= req_code;
      data_q <= req_data;
    end
  end

  tport_pacer #(.DIV_W(DIV_W)) u_pacer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .div_in   (step_div),
    .run      (busy),
    .step_end (step_end)
  );

  tport_stepper u_stepper (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .op       (req_op),
    .step_end (step_end),
    .state_d  (state_d),
    .busy     (busy)
  );

  tport_drive u_drive (
    .clk     (clk),
    .rst_n   (rst_n),
    .state_d (state_d),
    .code    (code_q),
    .data    (data_q),
    .pins    (pins)
  );

  assign tst_clk = pins.clk;
  assign tst_en  = pins.en;
  assign tst_clr = pins.clr;
  assign tst_din = pins.din;

  // R7: ready drops on the acceptance edge
  a_r7_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  // R2: while idle the port stays at rest
  a_r2_idle_rest: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (tst_clk && !tst_en && !tst_clr && tst_din == '0));
endmodule

// File: tb/phy_tport_seq_tb.sv
module phy_tport_seq_tb;
  localparam int DIV_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [DIV_W-1:0] step_div = '0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic             req_op = 1'b0;
  logic [7:0]       req_code = '0;
  logic [7:0]       req_data = '0;
  logic             tst_clk, tst_en, tst_clr;
  logic [7:0]       tst_din;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  phy_tport_seq #(.DIV_W(DIV_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .step_div(step_div),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_code(req_code), .req_data(req_data),
    .tst_clk(tst_clk), .tst_en(tst_en), .tst_clr(tst_clr), .tst_din(tst_din)
  );

  function automatic logic [10:0] exp_pins(bit op, logic [7:0] c, logic [7:0] d, int s);
    if (op) begin
      return (s == 1) ? {3'b101, 8'h00} : {3'b100, 8'h00};
    end
    case (s)
      0: return {3'b100, 8'h00};
      1: return {3'b110, c};
      2: return {3'b010, c};
      3: return {3'b000, d};
      default: return {3'b100, d};
    endcase
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [10:0] pins_now();
    return {tst_clk, tst_en, tst_clr, tst_din};
  endfunction

  // Called at a falling edge with the request presented and the block idle.
  task automatic run_op(bit op, logic [7:0] c, logic [7:0] d, int div, string tag,
                        bit nv, bit nop, logic [7:0] nc, logic [7:0] nd, int ndiv);
    int n;
    int steps;
    n = (div < 2) ? 2 : div;
    steps = op ? 3 : 5;
    chk(req_ready === 1'b1, {tag, " ready before accept"}, 32'(req_ready), 1);
    @(posedge clk);
    for (int s = 0; s < steps; s++) begin
      for (int k = 0; k < n; k++) begin
        @(negedge clk);
        if (s == 0 && k == 0) begin
          req_valid = nv; req_op = nop; req_code = nc; req_data = nd;
          step_div = DIV_W'(ndiv);
        end
        chk(pins_now() === exp_pins(op, c, d, s),
            op ? "R3 R6 clear step pins" : "R4 R6 write step pins",
            32'(pins_now()), 32'(exp_pins(op, c, d, s)));
        chk(req_ready === 1'b0, "R7 ready low while busy", 32'(req_ready), 0);
        if (!op && s == 2 && k == 0)
          chk(tst_clk === 1'b0 && tst_en === 1'b1 && tst_din === c,
              "R5 code on falling edge", 32'(pins_now()), 32'({3'b010, c}));
        if (!op && s == 4 && k == 0)
          chk(tst_clk === 1'b1 && tst_en === 1'b0 && tst_din === d,
              "R5 data on rising edge", 32'(pins_now()), 32'({3'b100, d}));
      end
    end
    @(negedge clk);
    chk(req_ready === 1'b1, "R7 ready back after S*N", 32'(req_ready), 1);
    chk(pins_now() === 11'h400, "R7 rest pins after sequence", 32'(pins_now()), 32'h400);
  endtask

  task automatic idle_check(int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      chk(req_ready === 1'b1, "R2 idle ready", 32'(req_ready), 1);
      chk(pins_now() === 11'h400, "R2 idle pins", 32'(pins_now()), 32'h400);
    end
  endtask

  initial begin
    #(5ns * 100000);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    bit cop, nop, nv;
    logic [7:0] cc, cd, nc, nd;
    int cdiv, ndiv;
    void'($urandom(32'd4711));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1, "R1 reset ready", 32'(req_ready), 1);
    chk(pins_now() === 11'h400, "R1 reset pins", 32'(pins_now()), 32'h400);
    idle_check(4);

    // Directed: clear with div 0 (clamped to 2), then chained write; step_div
    // changed mid-sequence must not alter the running clear (R6), and the
    // write held valid while busy must come through intact (R8).
    req_valid = 1; req_op = 1; req_code = 8'h00; req_data = 8'h00; step_div = 0;
    run_op(1, 8'h00, 8'h00, 0, "R3", 1, 0, 8'hA5, 8'h3C, 3);
    run_op(0, 8'hA5, 8'h3C, 3, "R8 stalled write", 1, 0, 8'hFF, 8'h00, 1);
    run_op(0, 8'hFF, 8'h00, 1, "R6 div one", 0, 0, 8'h00, 8'h00, 2);
    idle_check(3);

    cop = 0; cc = 8'h01; cd = 8'h80; cdiv = 5;
    req_valid = 1; req_op = cop; req_code = cc; req_data = cd; step_div = DIV_W'(cdiv);
    for (int i = 0; i < 40; i++) begin
      nop = ($urandom % 3) == 0;
      nc = 8'($urandom); nd = 8'($urandom);
      ndiv = $urandom % 7;
      nv = $urandom % 2;
      run_op(cop, cc, cd, cdiv, nv ? "R8 chained" : "R4 random", nv, nop, nc, nd, ndiv);
      if (!nv) begin
        idle_check(1 + $urandom % 3);
        req_valid = 1; req_op = nop; req_code = nc; req_data = nd;
        step_div = DIV_W'(ndiv);
      end
      cop = nop; cc = nc; cd = nd; cdiv = ndiv;
    end
    run_op(cop, cc, cd, cdiv, "R4 last", 0, 0, 8'h00, 8'h00, 2);
    idle_check(2);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule